// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

This block keeps the contents of an SDRAM alive by asking the command arbiter for the bus at a steady, distributed rate and issuing AUTO REFRESH commands once it owns the bus. An internal interval timer adds one unit of refresh debt every `INTERVAL` clock cycles. By default this is the 15.625 µs per-row period divided by the clock period. Debt may be postponed up to `PEND_MAX` units. At that limit the block raises an urgent flag so the arbiter can give it priority. Once granted, the block closes all open banks with a PRECHARGE-all if needed, waits the precharge recovery time, and then issues refreshes back to back, spaced by the refresh cycle time, until the debt is paid.

The same handshake also carries the low-power retention mode. While `sr_req` is high the block requests the bus. When granted, it precharges if needed and issues SELF REFRESH with CKE driven low in the same cycle. It keeps CKE low for at least `T_SR_MIN` cycles and ignores every other input until `sr_req` falls. Then it raises CKE and holds the bus for one refresh cycle time before handing it back. Refresh row addressing is not produced here, because the memory generates it internally.

Top module: `sdram_refresh_sched`

## Requirements
- R1: While `rst_n` is low, `cmd` is NOP (0), `cke` is 1, and `ref_req`, `ref_urgent` and `bus_own` are 0.
- R2: One unit of refresh debt is added every `INTERVAL` cycles. After reset release, `ref_req` first goes high `INTERVAL` cycles later. `ref_req` is high exactly when the block does not own the bus and either debt is nonzero or `sr_req` is high.
- R3: Debt saturates at `PEND_MAX`. `ref_urgent` is high exactly while debt equals `PEND_MAX`.
- R4: Suppose `ref_gnt` is sampled high while `ref_req` is high. If `banks_open` is 0, the cycle after the grant carries AUTO REFRESH (2). If `banks_open` is 1, that cycle carries PRECHARGE-all (1), and the next command follows exactly `T_RP` cycles after the PRECHARGE.
- R5: While debt remains after a refresh, the next AUTO REFRESH follows exactly `T_RFC` cycles after the previous one, without a new grant. `bus_own` falls `T_RFC` cycles after the last refresh.
- R6: `ref_gnt` has no effect while `ref_req` is low: no command is issued and `bus_own` stays 0.
- R7: When granted with `sr_req` high, the block enters self refresh instead of refreshing, even when debt is pending. It issues SELF REFRESH (3), with `cke` falling in that same cycle, and clears the debt.
- R8: `cke` stays low for at least `T_SR_MIN` cycles after SELF REFRESH, and for as long as `sr_req` stays high. While `cke` is low, `cmd` stays NOP and `ref_gnt` and `banks_open` have no effect. `cke` rises the cycle after the block samples `sr_req` low with the minimum time served.
- R9: After `cke` rises, `bus_own` stays high for `T_RFC` cycles. The interval timer is held during self refresh and restarts on release, so `ref_req` rises `INTERVAL` cycles after `bus_own` falls.
- R10: `cmd` is non-NOP only while `bus_own` is high, and `ref_req` is never high while `bus_own` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| banks_open | input | 1 | At least one bank is active; PRECHARGE-all is needed first |
| ref_gnt | input | 1 | Arbiter grants the command bus to this block |
| sr_req | input | 1 | High requests the retention mode; low requests exit |
| ref_req | output | 1 | Request for the command bus |
| ref_urgent | output | 1 | Refresh debt has reached its limit |
| bus_own | output | 1 | Block owns the command bus |
| cmd | output | 2 | 0 NOP, 1 PRECHARGE-all, 2 AUTO REFRESH, 3 SELF REFRESH |
| cke | output | 1 | Clock enable to the memory |

## Verification
The command is decoded from the state, so every command appears in the cycle after the clock edge that caused it. A grant produces its first command one cycle later. The refresh after a PRECHARGE comes `T_RP` cycles after it, and chained refreshes come `T_RFC` cycles apart. The first request appears `INTERVAL` cycles after reset release or after ownership is released. The bench drives inputs and samples outputs on falling edges and counts falling edges from the stimulus. Each check is made at exactly the count predicted by these latencies, with one check made a cycle early to show that the result is not there too soon.

// File: rtl/sdram_ref_pkg.sv
// Shared types for the SDRAM refresh scheduler.
// Assumes: command encoding is fixed and decoded by the command mux downstream.
package sdram_ref_pkg;

    typedef enum logic [1:0] {
        CMD_NOP      = 2'd0,
        CMD_PRE_ALL  = 2'd1,
        CMD_AUTO_REF = 2'd2,
        CMD_SELF_REF = 2'd3
    } ref_cmd_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PRE,
        S_TRP,
        S_REF,
        S_TRFC,
        S_SRE,
        S_DWELL,
        S_HOLD,
        S_XW
    } ref_state_e;

endpackage

// File: rtl/refresh_interval_timer.sv
// Free-running interval timer: pulses tick once every INTERVAL cycles.
// Assumes: hold clears the count and suppresses the tick (used during self refresh).
module refresh_interval_timer #(
    parameter int INTERVAL = 3906
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic tick
);
    localparam int CW = $clog2(INTERVAL + 1);
    localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

    logic [CW-1:0] cnt;

    assign tick = !hold && (cnt == LAST);

    // Count cycles, wrap at the interval, clear while held.
    always_ff @(posedge clk) begin
        if (!rst_n || hold || tick) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/refresh_debt_ctr.sv
// Saturating count of refreshes owed to the memory.
// Assumes: clr has priority; an inc and dec in the same cycle cancel.
module refresh_debt_ctr #(
    parameter int PEND_MAX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    input  logic clr,
    output logic empty,
    output logic full
);
    localparam int DW = $clog2(PEND_MAX + 1);
    localparam logic [DW-1:0] TOP = DW'(PEND_MAX);

    logic [DW-1:0] debt;

    assign empty = (debt == '0);
    assign full  = (debt == TOP);

    // Track owed refreshes, saturating at the top and floor.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)                 debt <= '0;
        else if (inc && !dec && !full)     debt <= debt + 1'b1;
        else if (dec && !inc && !empty)    debt <= debt - 1'b1;
    end
endmodule

// File: rtl/refresh_wait_timer.sv
// Down-counter for recovery and dwell waits; done when it reaches zero.
// Assumes: the owner loads it on entry to each wait state.
module refresh_wait_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          done
);
    logic [TW-1:0] tm;

    assign done = (tm == '0);

    // Load a new wait, otherwise count down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n)      tm <= '0;
        else if (load)   tm <= load_val;
        else if (!done)  tm <= tm - 1'b1;
    end
endmodule

// File: rtl/sdram_refresh_sched.sv
// SDRAM refresh scheduler: distributed AUTO REFRESH with debt catch-up,
// forced PRECHARGE-all, and self-refresh entry/exit with minimum dwell.
// Assumes: T_RP, T_RFC, T_SR_MIN >= 2; the arbiter grants only when idle
// and leaves the bus to this block while bus_own is high.
module sdram_refresh_sched #(
    parameter int CLK_PS   = 4000,
    parameter int INTERVAL = 15625000 / CLK_PS,
    parameter int T_RP     = 5,
    parameter int T_RFC    = 20,
    parameter int T_SR_MIN = 12,
    parameter int PEND_MAX = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       banks_open,
    input  logic       ref_gnt,
    input  logic       sr_req,
    output logic       ref_req,
    output logic       ref_urgent,
    output logic       bus_own,
    output logic [1:0] cmd,
    output logic       cke
);
    import sdram_ref_pkg::*;

    localparam int TMAX = (T_RP > T_RFC) ? ((T_RP > T_SR_MIN) ? T_RP : T_SR_MIN)
                                         : ((T_RFC > T_SR_MIN) ? T_RFC : T_SR_MIN);
    localparam int TW = $clog2(TMAX + 1);
    localparam logic [TW-1:0] LD_RP   = TW'(T_RP - 2);
    localparam logic [TW-1:0] LD_RFC  = TW'(T_RFC - 2);
    localparam logic [TW-1:0] LD_SR   = TW'(T_SR_MIN - 2);
    localparam logic [TW-1:0] LD_EXIT = TW'(T_RFC - 1);

    ref_state_e    st, nxt;
    logic          goal_sr;
    logic          tick, debt_empty, debt_full, in_sr;
    logic          tm_load, tm_done;
    logic [TW-1:0] tm_val;
    ref_cmd_e      cmd_q;

    assign in_sr = (st == S_SRE) || (st == S_DWELL) || (st == S_HOLD) || (st == S_XW);

    refresh_interval_timer #(.INTERVAL(INTERVAL)) u_ivl (
        .clk(clk), .rst_n(rst_n), .hold(in_sr), .tick(tick)
    );

    refresh_debt_ctr #(.PEND_MAX(PEND_MAX)) u_debt (
        .clk(clk), .rst_n(rst_n), .inc(tick), .dec(st == S_REF),
        .clr(st == S_SRE), .empty(debt_empty), .full(debt_full)
    );

    refresh_wait_timer #(.TW(TW)) u_wait (
        .clk(clk), .rst_n(rst_n), .load(tm_load), .load_val(tm_val), .done(tm_done)
    );

    // Next-state and wait-timer load decode.
    always_comb begin
        nxt     = st;
        tm_load = 1'b0;
        tm_val  = '0;
        case (st)
            S_IDLE:  if (ref_gnt && ref_req)
                         nxt = banks_open ? S_PRE : (sr_req ? S_SRE : S_REF);
            S_PRE:   begin nxt = S_TRP;   tm_load = 1'b1; tm_val = LD_RP;  end
            S_TRP:   if (tm_done) nxt = goal_sr ? S_SRE : S_REF;
            S_REF:   begin nxt = S_TRFC;  tm_load = 1'b1; tm_val = LD_RFC; end
            S_TRFC:  if (tm_done) nxt = debt_empty ? S_IDLE : S_REF;
            S_SRE:   begin nxt = S_DWELL; tm_load = 1'b1; tm_val = LD_SR;  end
            S_DWELL: if (tm_done) nxt = S_HOLD;
            S_HOLD:  if (!sr_req) begin nxt = S_XW; tm_load = 1'b1; tm_val = LD_EXIT; end
            S_XW:    if (tm_done) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // State register and latched goal of the current ownership.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            goal_sr <= 1'b0;
        end else begin
            st <= nxt;
            if (st == S_IDLE && ref_gnt && ref_req) goal_sr <= sr_req;
        end
    end

    // Command decode from the current state.
    always_comb begin
        case (st)
            S_PRE:   cmd_q = CMD_PRE_ALL;
            S_REF:   cmd_q = CMD_AUTO_REF;
            S_SRE:   cmd_q = CMD_SELF_REF;
            default: cmd_q = CMD_NOP;
        endcase
    end

    assign cmd        = cmd_q;
    assign cke        = !((st == S_SRE) || (st == S_DWELL) || (st == S_HOLD));
    assign bus_own    = (st != S_IDLE);
    assign ref_req    = (st == S_IDLE) && (!debt_empty || sr_req);
    assign ref_urgent = debt_full;
endmodule

// File: rtl/sdram_refresh_sched_chk.sv
// Protocol checker for the refresh scheduler, bound to the top module.
// Assumes: observes ports only; gap and low-CKE counters saturate at 16 bits.
module sdram_refresh_sched_chk #(
    parameter int T_RP     = 5,
    parameter int T_RFC    = 20,
    parameter int T_SR_MIN = 12
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ref_req,
    input logic       ref_urgent,
    input logic       bus_own,
    input logic [1:0] cmd,
    input logic       cke
);
    logic [15:0] gap, lowcnt;
    logic [1:0]  last_cmd;

    // Cycles since the last non-NOP command and what it was.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap      <= 16'hFFFF;
            last_cmd <= 2'd0;
        end else if (cmd != 2'd0) begin
            gap      <= 16'd1;
            last_cmd <= cmd;
        end else if (gap != 16'hFFFF) begin
            gap <= gap + 16'd1;
        end
    end

    // Cycles spent with CKE low.
    always_ff @(posedge clk) begin
        if (!rst_n || cke)          lowcnt <= '0;
        else if (lowcnt != 16'hFFFF) lowcnt <= lowcnt + 16'd1;
    end

    initial begin
        AST_PARAM_RANGE: assert (T_RP >= 2 && T_RFC >= 2 && T_SR_MIN >= 2); // R4
    end

    AST_REF_AFTER_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != 2'd0 && last_cmd == 2'd1) |-> gap == 16'(T_RP)); // R4
    AST_REF_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'd2 && last_cmd == 2'd2) |-> gap >= 16'(T_RFC)); // R5
    AST_CKE_FALL_SRE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> cmd == 2'd3); // R7
    AST_SR_DWELL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> lowcnt >= 16'(T_SR_MIN)); // R8
    AST_LOW_CKE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && cmd != 2'd3) |-> cmd == 2'd0); // R8
    AST_EXIT_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> bus_own); // R9
    AST_CMD_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        cmd != 2'd0 |-> bus_own); // R10
    AST_NO_REQ_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_own |-> !ref_req); // R10
    AST_URGENT_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        ref_urgent |-> (ref_req || bus_own)); // R3
endmodule

bind sdram_refresh_sched sdram_refresh_sched_chk #(
    .T_RP(T_RP), .T_RFC(T_RFC), .T_SR_MIN(T_SR_MIN)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .ref_urgent(ref_urgent),
    .bus_own(bus_own), .cmd(cmd), .cke(cke)
);

// File: tb/sdram_refresh_sched_test.sv
// Bench for the refresh scheduler: a vector table of grant scenarios,
// then directed tests for reset, interval, saturation and self refresh.
module sdram_refresh_sched_test;
    localparam int INTERVAL = 40;
    localparam int T_RP     = 3;
    localparam int T_RFC    = 4;
    localparam int T_SR_MIN = 8;
    localparam int PEND_MAX = 8;

    // {banks_open, expected PRE cycle, expected REF cycle, expected release cycle}
    localparam logic [13:0] VEC [4] = '{
        {1'b1, 4'd1, 4'd4, 5'd8},
        {1'b0, 4'd0, 4'd1, 5'd5},
        {1'b0, 4'd0, 4'd1, 5'd5},
        {1'b1, 4'd1, 4'd4, 5'd8}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic banks_open = 1'b0, ref_gnt = 1'b0, sr_req = 1'b0;
    logic ref_req, ref_urgent, bus_own, cke;
    logic [1:0] cmd;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sdram_refresh_sched #(
        .INTERVAL(INTERVAL), .T_RP(T_RP), .T_RFC(T_RFC),
        .T_SR_MIN(T_SR_MIN), .PEND_MAX(PEND_MAX)
    ) uut (
        .clk(clk), .rst_n(rst_n), .banks_open(banks_open), .ref_gnt(ref_gnt),
        .sr_req(sr_req), .ref_req(ref_req), .ref_urgent(ref_urgent),
        .bus_own(bus_own), .cmd(cmd), .cke(cke)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic wait_req();
        for (int i = 0; i < 200 && !ref_req; i++) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int pre_n, ref_n, rel_n, sre_n, rise_n, low_n, refs, last_ref, bad_gap, quiet;
        step(3);
        // R1 reset state
        check("R1 cmd", cmd, 0);
        check("R1 cke", cke, 1);
        check("R1 ref_req", ref_req, 0);
        check("R1 ref_urgent", ref_urgent, 0);
        check("R1 bus_own", bus_own, 0);
        rst_n = 1'b1;                       // falling edge 0
        step(5); ref_gnt = 1'b1;            // R6 grant with no request
        step(1); ref_gnt = 1'b0;
        check("R6 bus_own", bus_own, 0);
        check("R6 cmd", cmd, 0);
        step(33);                           // edge 39
        check("R2 ref_req early", ref_req, 0);
        step(1);                            // edge 40
        check("R2 ref_req", ref_req, 1);
        step(279);                          // edge 319
        check("R3 urgent early", ref_urgent, 0);
        step(1);                            // edge 320
        check("R3 urgent", ref_urgent, 1);
        step(85);                           // edge 405
        ref_gnt = 1'b1;
        refs = 0; last_ref = 0; bad_gap = 0; rel_n = 0;
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            ref_gnt = 1'b0;
            if (cmd == 2'd2) begin
                if (refs > 0 && k - last_ref != T_RFC) bad_gap++;
                refs++; last_ref = k;
            end
            if (!bus_own && rel_n == 0) rel_n = k;
        end
        check("R5 catch-up count", refs, PEND_MAX);
        check("R5 spacing errors", bad_gap, 0);
        check("R5 release cycle", rel_n, 33);
        check("R3 urgent cleared", ref_urgent, 0);

        // Vector table: grant with and without open banks (R4, R5)
        rst_n = 1'b0; step(2); rst_n = 1'b1;
        foreach (VEC[i]) begin
            wait_req();
            banks_open = VEC[i][13];
            ref_gnt = 1'b1;
            pre_n = 0; ref_n = 0; rel_n = 0;
            for (int k = 1; k <= 12; k++) begin
                @(negedge clk);
                ref_gnt = 1'b0;
                if (cmd == 2'd1 && pre_n == 0) pre_n = k;
                if (cmd == 2'd2 && ref_n == 0) ref_n = k;
                if (!bus_own && rel_n == 0) rel_n = k;
            end
            banks_open = 1'b0;
            check("R4 precharge cycle", pre_n, int'(VEC[i][12:9]));
            check("R4 refresh cycle", ref_n, int'(VEC[i][8:5]));
            check("R5 release cycle", rel_n, int'(VEC[i][4:0]));
        end

        // Self refresh with open banks (R7, R8, R9)
        step(1);
        sr_req = 1'b1; banks_open = 1'b1;
        #1 check("R7 ref_req on sr_req", ref_req, 1);
        ref_gnt = 1'b1;
        pre_n = 0; sre_n = 0; low_n = 0; rise_n = 0; rel_n = 0; quiet = 0;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            ref_gnt = (k >= 6 && k <= 9);
            banks_open = (k < 3) || (k >= 6 && k <= 9);
            if (cmd == 2'd1 && pre_n == 0) pre_n = k;
            if (cmd == 2'd3 && sre_n == 0) begin sre_n = k; sr_req = 1'b0; end
            if (!cke && low_n == 0) low_n = k;
            if (sre_n != 0 && k > sre_n && cke && rise_n == 0) rise_n = k;
            if (k > 4 && k < 13 && cmd != 2'd0) quiet++;
            if (!bus_own && rel_n == 0) rel_n = k;
        end
        banks_open = 1'b0;
        check("R4 precharge before entry", pre_n, 1);
        check("R7 self refresh cycle", sre_n, 4);
        check("R7 cke low with entry", low_n, 4);
        check("R8 commands while cke low", quiet, 0);
        check("R8 cke rise", rise_n, 13);
        check("R9 release cycle", rel_n, 17);
        step(36);                           // 39 cycles after release
        check("R9 ref_req early", ref_req, 0);
        step(1);
        check("R9 ref_req restart", ref_req, 1);

        // Self refresh with closed banks while debt pending (R7, R8)
        sr_req = 1'b1;
        ref_gnt = 1'b1;
        @(negedge clk); ref_gnt = 1'b0;
        check("R7 entry beats refresh", cmd, 3);
        step(29);                           // cycle 30, sr_req still high
        check("R8 cke held low", cke, 0);
        sr_req = 1'b0;
        step(1);
        check("R8 cke rise after request drop", cke, 1);
        step(3);
        check("R9 owned during exit wait", bus_own, 1);
        step(1);
        check("R9 released", bus_own, 0);
        check("R7 debt cleared", ref_req, 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule